// File: doc/BRIEF.md
# Key Register Same-Writer Guard

This unit holds a cipher key as a set of 32-bit words. Several bus initiators can write these words, and every write carries the ID of the initiator that made it. The unit records which words have been written and which initiator wrote them. It reports the key as valid only when one initiator has written every word. A write from any other initiator removes the valid status at once. Validity returns only after that new initiator has written the whole key itself.

A second write path models a secure key store. It loads words under a fixed, reserved initiator ID. In any cycle where both paths write, the key store wins. Cipher start requests pass through the unit. A start is let through only while the key is valid. A start made without a valid key is dropped and raises a sticky error flag, which stays set until software clears it.

Top module: `key_writer_guard`

## Requirements
- R1: `key_o` is the key words joined together, with word i at bits [32i+31:32i]. A write to word i replaces that word at the clock edge where the write is presented. When no write is presented, `key_o` holds its value.
- R2: After reset, `key_valid_o` is 0, `key_o` is all zeros, `start_err_o` is 0, no word is marked as written, and the tracked initiator ID is 0.
- R3: A write whose ID differs from the tracked ID has three effects at its clock edge. It drives `key_valid_o` low, makes that ID the tracked one, and leaves only the written word marked. The written data is still stored.
- R4: `key_valid_o` rises one cycle after the edge on which the tracked initiator marks the last unwritten word. It is never high while any word is unmarked, so writes that interleave between initiators never produce a valid key.
- R5: While the key is valid, further writes from the tracked initiator keep `key_valid_o` high.
- R6: In the same cycle, `start_o` equals `start_i` when `key_valid_o` is 1, and is 0 when `key_valid_o` is 0.
- R7: A start request made while `key_valid_o` is 0 sets `start_err_o` at the next edge. The flag stays set until `err_clr_i` is pulsed. The clear takes effect at the next edge. If a refused start and a clear occur in the same cycle, the flag stays set.
- R8: The key-store path (`ks_we_i`) writes under the ID `KS_ID` (default 7). If the bus path writes in the same cycle, the bus write is ignored: its data is not stored and its ID is not tracked.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_we_i | input | 1 | Bus key-word write strobe |
| bus_idx_i | input | 2 | Bus word index |
| bus_data_i | input | 32 | Bus write data |
| bus_id_i | input | 3 | ID of the initiator making the bus write |
| ks_we_i | input | 1 | Key-store load strobe |
| ks_idx_i | input | 2 | Key-store word index |
| ks_data_i | input | 32 | Key-store load data |
| start_i | input | 1 | Cipher start request |
| err_clr_i | input | 1 | Clear for the refused-start flag |
| key_o | output | 128 | Assembled key |
| key_valid_o | output | 1 | Key fully written by a single initiator |
| start_o | output | 1 | Gated cipher start |
| start_err_o | output | 1 | Sticky refused-start flag |

## Verification
The assertions assume that every write index is in range and that strobes are single-cycle, with known values once reset is released. The properties that involve ownership rely on the tracked ID and the written-word mask, which the checker reads through the bind. The stimulus meets these assumptions in three ways. Each write is driven for one cycle. Every index stays inside the word count. Inputs change only on the falling clock edge, so the properties never see a change in the middle of a cycle.

// File: rtl/key_writer_guard_pkg.sv
package key_writer_guard_pkg;
   typedef enum logic {
      SRC_BUS = 1'b0,
      SRC_KS  = 1'b1
   } wr_src_e;

   function automatic int unsigned idx_width(input int unsigned n);
      return (n <= 2) ? 1 : $clog2(n);
   endfunction
endpackage

// File: rtl/kg_write_mux.sv
module kg_write_mux #(
   parameter int unsigned WORD_W = 32,
   parameter int unsigned IDX_W  = 2,
   parameter int unsigned ID_W   = 3,
   parameter int unsigned KS_ID  = 7
) (
   input  logic              bus_we,
   input  logic [IDX_W-1:0]  bus_idx,
   input  logic [WORD_W-1:0] bus_data,
   input  logic [ID_W-1:0]   bus_id,
   input  logic              ks_we,
   input  logic [IDX_W-1:0]  ks_idx,
   input  logic [WORD_W-1:0] ks_data,
   output logic              wr_en,
   output logic [IDX_W-1:0]  wr_idx,
   output logic [WORD_W-1:0] wr_data,
   output logic [ID_W-1:0]   wr_id
);
   import key_writer_guard_pkg::*;

   localparam logic [ID_W-1:0] KS_ID_V = ID_W'(KS_ID);

   wr_src_e src;

   always_comb begin
      src     = ks_we ? SRC_KS : SRC_BUS;
      wr_en   = ks_we | bus_we;
      wr_idx  = (src == SRC_KS) ? ks_idx  : bus_idx;
      wr_data = (src == SRC_KS) ? ks_data : bus_data;
      wr_id   = (src == SRC_KS) ? KS_ID_V : bus_id;
   end
endmodule

// File: rtl/kg_word_bank.sv
module kg_word_bank #(
   parameter int unsigned WORD_W    = 32,
   parameter int unsigned NUM_WORDS = 4,
   parameter int unsigned IDX_W     = 2
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        wr_en,
   input  logic [IDX_W-1:0]            wr_idx,
   input  logic [WORD_W-1:0]           wr_data,
   output logic [NUM_WORDS*WORD_W-1:0] key
);
   for (genvar w = 0; w < NUM_WORDS; w++) begin : g_word
      logic [WORD_W-1:0] word_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            word_q <= '0;
         end else if (wr_en && (wr_idx == IDX_W'(w))) begin
            word_q <= wr_data;
         end
      end
      assign key[w*WORD_W +: WORD_W] = word_q;
   end
endmodule

// File: rtl/kg_owner_track.sv
module kg_owner_track #(
   parameter int unsigned NUM_WORDS = 4,
   parameter int unsigned IDX_W     = 2,
   parameter int unsigned ID_W      = 3
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 wr_en,
   input  logic [IDX_W-1:0]     wr_idx,
   input  logic [ID_W-1:0]      wr_id,
   output logic [NUM_WORDS-1:0] mask,
   output logic [ID_W-1:0]      owner,
   output logic                 valid
);
   logic [NUM_WORDS-1:0] sel;
   logic                 foreign;
   logic                 full;

   always_comb begin
      sel = '0;
      for (int i = 0; i < NUM_WORDS; i++) begin
         if (wr_idx == IDX_W'(i)) sel[i] = 1'b1;
      end
      foreign = wr_en && (wr_id != owner);
      full    = &mask;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mask  <= '0;
         owner <= '0;
         valid <= 1'b0;
      end else begin
         valid <= full && !foreign;
         if (wr_en) begin
            if (foreign) begin
               owner <= wr_id;
               mask  <= sel;
            end else begin
               mask  <= mask | sel;
            end
         end
      end
   end
endmodule

// File: rtl/kg_start_gate.sv
module kg_start_gate (
   input  logic clk,
   input  logic rst_n,
   input  logic valid,
   input  logic start_req,
   input  logic err_clr,
   output logic start_out,
   output logic err
);
   logic refused;

   always_comb begin
      refused   = start_req && !valid;
      start_out = start_req && valid;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       err <= 1'b0;
      else if (refused) err <= 1'b1;
      else if (err_clr) err <= 1'b0;
   end
endmodule

// File: rtl/key_writer_guard.sv
module key_writer_guard #(
   parameter int unsigned WORD_W    = 32,
   parameter int unsigned NUM_WORDS = 4,
   parameter int unsigned ID_W      = 3,
   parameter int unsigned KS_ID     = 7,
   parameter int unsigned IDX_W     = key_writer_guard_pkg::idx_width(NUM_WORDS),
   parameter int unsigned KEY_W     = WORD_W * NUM_WORDS
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_we_i,
   input  logic [IDX_W-1:0]  bus_idx_i,
   input  logic [WORD_W-1:0] bus_data_i,
   input  logic [ID_W-1:0]   bus_id_i,
   input  logic              ks_we_i,
   input  logic [IDX_W-1:0]  ks_idx_i,
   input  logic [WORD_W-1:0] ks_data_i,
   input  logic              start_i,
   input  logic              err_clr_i,
   output logic [KEY_W-1:0]  key_o,
   output logic              key_valid_o,
   output logic              start_o,
   output logic              start_err_o
);
   if (NUM_WORDS < 2) begin : g_bad_words
      $error("key_writer_guard: NUM_WORDS must be at least 2");
   end
   if (KS_ID >= (1 << ID_W)) begin : g_bad_ks_id
      $error("key_writer_guard: KS_ID does not fit in ID_W bits");
   end
   if (KEY_W != WORD_W * NUM_WORDS) begin : g_bad_key_w
      $error("key_writer_guard: KEY_W must equal WORD_W*NUM_WORDS");
   end

   logic                 wr_en;
   logic [IDX_W-1:0]     wr_idx;
   logic [WORD_W-1:0]    wr_data;
   logic [ID_W-1:0]      wr_id;
   logic [NUM_WORDS-1:0] mask;
   logic [ID_W-1:0]      owner;

   kg_write_mux #(.WORD_W(WORD_W), .IDX_W(IDX_W), .ID_W(ID_W), .KS_ID(KS_ID)) u_mux (
      .bus_we(bus_we_i), .bus_idx(bus_idx_i), .bus_data(bus_data_i), .bus_id(bus_id_i),
      .ks_we(ks_we_i), .ks_idx(ks_idx_i), .ks_data(ks_data_i),
      .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data), .wr_id(wr_id)
   );

   kg_word_bank #(.WORD_W(WORD_W), .NUM_WORDS(NUM_WORDS), .IDX_W(IDX_W)) u_bank (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
      .key(key_o)
   );

   kg_owner_track #(.NUM_WORDS(NUM_WORDS), .IDX_W(IDX_W), .ID_W(ID_W)) u_track (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(wr_idx), .wr_id(wr_id),
      .mask(mask), .owner(owner), .valid(key_valid_o)
   );

   kg_start_gate u_gate (
      .clk(clk), .rst_n(rst_n), .valid(key_valid_o), .start_req(start_i),
      .err_clr(err_clr_i), .start_out(start_o), .err(start_err_o)
   );
endmodule

module key_writer_guard_chk #(
   parameter int unsigned NUM_WORDS = 4,
   parameter int unsigned ID_W      = 3,
   parameter int unsigned KEY_W     = 128
) (
   input logic                 clk,
   input logic                 rst_n,
   input logic                 wr_en,
   input logic [ID_W-1:0]      wr_id,
   input logic [ID_W-1:0]      owner,
   input logic [NUM_WORDS-1:0] mask,
   input logic [KEY_W-1:0]     key_o,
   input logic                 key_valid_o,
   input logic                 start_i,
   input logic                 start_o,
   input logic                 start_err_o
);
   AST_KEY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_en |=> $stable(key_o)); // R1
   AST_FOREIGN_DROP: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && (wr_id != owner)) |=> (!key_valid_o && (owner == $past(wr_id)) && $onehot(mask))); // R3
   AST_VALID_FULL: assert property (@(posedge clk) disable iff (!rst_n)
      key_valid_o |-> (&mask)); // R4
   AST_VALID_RISE: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(key_valid_o) |-> $past(&mask)); // R4
   AST_OWNER_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
      (key_valid_o && wr_en && (wr_id == owner)) |=> key_valid_o); // R5
   AST_START_BLOCK: assert property (@(posedge clk) disable iff (!rst_n)
      start_o |-> key_valid_o); // R6
   AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      (start_i && !key_valid_o) |=> start_err_o); // R7
endmodule

bind key_writer_guard key_writer_guard_chk #(
   .NUM_WORDS(NUM_WORDS), .ID_W(ID_W), .KEY_W(KEY_W)
) u_chk (
   .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_id(wr_id), .owner(owner), .mask(mask),
   .key_o(key_o), .key_valid_o(key_valid_o), .start_i(start_i), .start_o(start_o),
   .start_err_o(start_err_o)
);

// File: tb/key_writer_guard_test.sv
module key_writer_guard_test;
   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         bus_we_i = 1'b0;
   logic [1:0]   bus_idx_i = '0;
   logic [31:0]  bus_data_i = '0;
   logic [2:0]   bus_id_i = '0;
   logic         ks_we_i = 1'b0;
   logic [1:0]   ks_idx_i = '0;
   logic [31:0]  ks_data_i = '0;
   logic         start_i = 1'b0;
   logic         err_clr_i = 1'b0;
   logic [127:0] key_o;
   logic         key_valid_o;
   logic         start_o;
   logic         start_err_o;

   int checks = 0;
   int failures = 0;
   logic [31:0] exp_w [4];

   key_writer_guard uut (.*);

   always #10 clk = ~clk;

   initial begin
      #2000000;
      failures++;
      $display("FAIL watchdog: run did not finish, actual=hung expected=done");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   task automatic chk(input string req, input logic [127:0] act, input logic [127:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s: actual=%h expected=%h", req, act, exp);
      end
   endtask

   function automatic logic [127:0] exp_key();
      return {exp_w[3], exp_w[2], exp_w[1], exp_w[0]};
   endfunction

   task automatic bus_wr(input logic [1:0] idx, input logic [31:0] d, input logic [2:0] id);
      @(negedge clk);
      bus_we_i = 1'b1; bus_idx_i = idx; bus_data_i = d; bus_id_i = id;
      @(negedge clk);
      bus_we_i = 1'b0;
      exp_w[idx] = d;
   endtask

   task automatic full_wr(input logic [2:0] id, input logic [31:0] base);
      for (int i = 0; i < 4; i++) bus_wr(2'(i), base + 32'(i), id);
   endtask

   task automatic t_reset();
      chk("R2 valid", {127'd0, key_valid_o}, 128'd0);
      chk("R2 key", key_o, 128'd0);
      chk("R2 err", {127'd0, start_err_o}, 128'd0);
   endtask

   task automatic t_refused_start();
      @(negedge clk);
      start_i = 1'b1; #1;
      chk("R6 blocked", {127'd0, start_o}, 128'd0);
      @(negedge clk);
      start_i = 1'b0;
      chk("R7 err set", {127'd0, start_err_o}, 128'd1);
      @(negedge clk);
      chk("R7 err sticky", {127'd0, start_err_o}, 128'd1);
      err_clr_i = 1'b1;
      @(negedge clk);
      err_clr_i = 1'b0;
      chk("R7 err cleared", {127'd0, start_err_o}, 128'd0);
      start_i = 1'b1; err_clr_i = 1'b1;
      @(negedge clk);
      start_i = 1'b0; err_clr_i = 1'b0;
      chk("R7 set wins", {127'd0, start_err_o}, 128'd1);
      err_clr_i = 1'b1;
      @(negedge clk);
      err_clr_i = 1'b0;
   endtask

   task automatic t_full_write();
      full_wr(3'd2, 32'hA000_0000);
      chk("R1 key", key_o, exp_key());
      chk("R4 not yet", {127'd0, key_valid_o}, 128'd0);
      @(negedge clk);
      chk("R4 valid", {127'd0, key_valid_o}, 128'd1);
      start_i = 1'b1; #1;
      chk("R6 pass", {127'd0, start_o}, 128'd1);
      @(negedge clk);
      start_i = 1'b0;
      chk("R7 no err", {127'd0, start_err_o}, 128'd0);
   endtask

   task automatic t_owner_rewrite();
      bus_wr(2'd3, 32'h1234_5678, 3'd2);
      chk("R5 still valid", {127'd0, key_valid_o}, 128'd1);
      chk("R1 rewrite", key_o, exp_key());
   endtask

   task automatic t_foreign();
      bus_wr(2'd1, 32'hBEEF_0001, 3'd5);
      chk("R3 dropped", {127'd0, key_valid_o}, 128'd0);
      chk("R3 stored", key_o, exp_key());
      bus_wr(2'd0, 32'hBEEF_0000, 3'd5);
      bus_wr(2'd2, 32'hBEEF_0002, 3'd5);
      chk("R4 partial", {127'd0, key_valid_o}, 128'd0);
      bus_wr(2'd3, 32'hBEEF_0003, 3'd5);
      @(negedge clk);
      chk("R3 new owner valid", {127'd0, key_valid_o}, 128'd1);
   endtask

   task automatic t_interleave();
      bus_wr(2'd0, 32'h1, 3'd1);
      bus_wr(2'd1, 32'h2, 3'd1);
      bus_wr(2'd2, 32'h3, 3'd3);
      bus_wr(2'd2, 32'h4, 3'd1);
      bus_wr(2'd3, 32'h5, 3'd1);
      @(negedge clk);
      @(negedge clk);
      chk("R4 interleave", {127'd0, key_valid_o}, 128'd0);
      chk("R1 interleave key", key_o, exp_key());
   endtask

   task automatic t_keystore();
      for (int i = 0; i < 4; i++) begin
         @(negedge clk);
         ks_we_i = 1'b1; ks_idx_i = 2'(i); ks_data_i = 32'hC0DE_0000 + 32'(i);
         @(negedge clk);
         ks_we_i = 1'b0;
         exp_w[i] = 32'hC0DE_0000 + 32'(i);
      end
      @(negedge clk);
      chk("R8 ks valid", {127'd0, key_valid_o}, 128'd1);
      @(negedge clk);
      ks_we_i = 1'b1; ks_idx_i = 2'd1; ks_data_i = 32'h5555_5555;
      bus_we_i = 1'b1; bus_idx_i = 2'd0; bus_data_i = 32'hDEAD_DEAD; bus_id_i = 3'd2;
      @(negedge clk);
      ks_we_i = 1'b0; bus_we_i = 1'b0;
      exp_w[1] = 32'h5555_5555;
      chk("R8 bus ignored", key_o, exp_key());
      @(negedge clk);
      chk("R8 ks owner kept", {127'd0, key_valid_o}, 128'd1);
   endtask

   initial begin
      for (int i = 0; i < 4; i++) exp_w[i] = '0;
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_refused_start();
      t_full_write();
      t_owner_rewrite();
      t_foreign();
      t_interleave();
      t_keystore();
      repeat (2) @(negedge clk);
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule